// File: doc/BRIEF.md
# Multiplexed Microcontroller Bus Slave

This block sits behind the pins of an 8-bit microcontroller bus that shares its low address byte with its data byte. It samples every bus input through a two-flop synchroniser and works entirely on the core clock. When the address strobe falls, it captures the low address byte from the shared lines and the high address bits from their own inputs. At the same moment it samples chip select and records whether the coming accesses belong to this device.

Three active-low strobes follow: program fetch, data read and write. A fetch or a data read turns into a one-cycle read request on a synchronous memory port. The returned byte is held on the data output, and the output enable stays high only while the strobe is held low. A write strobe arms a write. The byte seen on the shared lines while the strobe is low becomes a one-cycle write request once the strobe is released. Any sample with more than one strobe low counts as a bus fault, and the block then issues no access. The pad tristate is left to the caller as separate in, out and enable signals.

Top module: `mux_bus_slave`

## Requirements
- R1: After reset, `ad_oe_o`, `mem_rd_o` and `mem_wr_o` are low.
- R2: On a high-to-low transition of `ale_i`, the address `{hi_i, ad_i}` is captured. The next access presents it on `mem_addr_o`, with `hi_i` in the upper 5 bits and `ad_i` in the lower 8.
- R3: If `cs_n_i` is high when `ale_i` falls, no read or write request follows until the next `ale_i` fall. This holds even if `cs_n_i` goes low in between.
- R4: With `fetch_n_i` low and `rd_n_i`, `wr_n_i` high, the block issues one read request. Within 8 cycles it drives the returned byte on `ad_o`, with `ad_oe_o` high.
- R5: With `rd_n_i` low and `fetch_n_i`, `wr_n_i` high, the block behaves as in R4.
- R6: With `wr_n_i` low and both read strobes high, a single write request follows the rising edge of `wr_n_i`. It carries the byte present on `ad_i` while the strobe was low and the latched address.
- R7: A sample in which two or more strobes are low issues no request and keeps `ad_oe_o` low. A write armed before such a sample is cancelled.
- R8: `ad_oe_o` falls within 3 cycles after the read strobe returns high at the pin.
- R9: A read strobe held low for any length of time issues exactly one read request.
- R10: `mem_rd_o` and `mem_wr_o` are single-cycle pulses and are never high together.
- R11: Changes on `ad_i` after `ale_i` has fallen do not alter the address of the following access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ad_i | input | LO_W | Shared address/data lines, input side |
| hi_i | input | HI_W | Dedicated high address lines |
| ale_i | input | 1 | Address strobe; address captured on its fall |
| cs_n_i | input | 1 | Active-low device select, sampled at address capture |
| fetch_n_i | input | 1 | Active-low program fetch strobe |
| rd_n_i | input | 1 | Active-low data read strobe |
| wr_n_i | input | 1 | Active-low write strobe |
| ad_o | output | LO_W | Read data for the shared lines |
| ad_oe_o | output | 1 | Output enable for the shared lines |
| mem_addr_o | output | LO_W+HI_W | Memory port address |
| mem_rd_o | output | 1 | One-cycle read request |
| mem_wr_o | output | 1 | One-cycle write request |
| mem_wdata_o | output | LO_W | Write data |
| mem_rdata_i | input | LO_W | Read data, valid the cycle after a read request |

## Verification
Two events can land on the same clock edge: a write is released, and a fresh address capture begins, because the write strobe rises in the same sample in which the address strobe falls. The bench raises the address strobe with a new address while a write is pending. It then lowers the address strobe and raises the write strobe on the same clock. The write request must carry the old address, and a read issued afterwards must carry the new one.

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int LO_W = 8,
  parameter int HI_W = 5
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [LO_W-1:0]      ad_i,
  input  logic [HI_W-1:0]      hi_i,
  input  logic                 ale_i,
  input  logic                 cs_n_i,
  input  logic                 fetch_n_i,
  input  logic                 rd_n_i,
  input  logic                 wr_n_i,
  output logic [LO_W-1:0]      ad_o,
  output logic                 ad_oe_o,
  output logic [LO_W+HI_W-1:0] mem_addr_o,
  output logic                 mem_rd_o,
  output logic                 mem_wr_o,
  output logic [LO_W-1:0]      mem_wdata_o,
  input  logic [LO_W-1:0]      mem_rdata_i
);

  localparam int AW = LO_W + HI_W;
  localparam int SW = AW + 5;
  localparam logic [SW-1:0] SYNC_RST = {{(AW+1){1'b0}}, 4'b1111};

  logic [SW-1:0] sync1, sync2;
  logic [LO_W-1:0] ad_s;
  logic [HI_W-1:0] hi_s;
  logic ale_s, cs_s, fe_s, rd_s, wr_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sync1 <= SYNC_RST;
      sync2 <= SYNC_RST;
    end else begin
      sync1 <= {ad_i, hi_i, ale_i, cs_n_i, fetch_n_i, rd_n_i, wr_n_i};
      sync2 <= sync1;
    end

  assign {ad_s, hi_s, ale_s, cs_s, fe_s, rd_s, wr_s} = sync2;

  logic ale_d;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ale_d <= 1'b0;
    else        ale_d <= ale_s;

  logic ale_fall, multi_low, rd_leg, wr_leg;
  assign ale_fall  = ale_d & ~ale_s;
  assign multi_low = (~fe_s & ~rd_s) | (~fe_s & ~wr_s) | (~rd_s & ~wr_s);
  assign rd_leg    = (~fe_s & rd_s & wr_s) | (fe_s & ~rd_s & wr_s);
  assign wr_leg    = fe_s & rd_s & ~wr_s;

  logic [AW-1:0]   alat;
  logic            sel;
  logic            rd_busy, rd_wait, rd_valid, wr_arm;
  logic [LO_W-1:0] dout, wbuf;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      alat        <= '0;
      sel         <= 1'b0;
      mem_addr_o  <= '0;
      mem_rd_o    <= 1'b0;
      mem_wr_o    <= 1'b0;
      mem_wdata_o <= '0;
      rd_busy     <= 1'b0;
      rd_wait     <= 1'b0;
      rd_valid    <= 1'b0;
      dout        <= '0;
      wbuf        <= '0;
      wr_arm      <= 1'b0;
    end else begin
      mem_rd_o <= 1'b0;
      mem_wr_o <= 1'b0;
      rd_wait  <= mem_rd_o;

      if (ale_fall) begin
        alat <= {hi_s, ad_s};
        sel  <= ~cs_s;
      end

      if (rd_leg && sel && !rd_busy) begin
        mem_rd_o   <= 1'b1;
        mem_addr_o <= alat;
        rd_busy    <= 1'b1;
      end else if (!rd_leg) begin
        rd_busy <= 1'b0;
      end

      if (!rd_leg)      rd_valid <= 1'b0;
      else if (rd_wait) begin
        rd_valid <= 1'b1;
        dout     <= mem_rdata_i;
      end

      if (wr_leg) wbuf <= ad_s;

      if (multi_low) begin
        wr_arm <= 1'b0;
      end else if (wr_leg && sel) begin
        wr_arm <= 1'b1;
      end else if (wr_arm && wr_s) begin
        wr_arm <= 1'b0;
        if (fe_s && rd_s) begin
          mem_wr_o    <= 1'b1;
          mem_wdata_o <= wbuf;
          mem_addr_o  <= alat;
        end
      end
    end

  assign ad_oe_o = rd_valid & rd_leg;
  assign ad_o    = dout;

endmodule

// File: rtl/mux_bus_slave_chk.sv
module mux_bus_slave_chk #(
  parameter int LO_W = 8,
  parameter int HI_W = 5
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fetch_n_i,
  input logic                 rd_n_i,
  input logic                 ad_oe_o,
  input logic [LO_W+HI_W-1:0] mem_addr_o,
  input logic                 mem_rd_o,
  input logic                 mem_wr_o
);

  logic rd_seen;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        rd_seen <= 1'b0;
    else if (mem_rd_o) rd_seen <= 1'b1;
    else if (ad_oe_o)  rd_seen <= 1'b0;

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_o && mem_wr_o));

  a_r10_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_o |=> !mem_rd_o);

  a_r10_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_o |=> !mem_wr_o);

  a_r8_oe_needs_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> (!$past(fetch_n_i, 2) || !$past(rd_n_i, 2)));

  a_r4_oe_after_request: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe_o) |-> rd_seen);

  a_r2_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (ad_oe_o && $past(ad_oe_o)) |-> $stable(mem_addr_o));

  a_r7_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe_o |-> !mem_wr_o);

endmodule

bind mux_bus_slave mux_bus_slave_chk #(.LO_W(LO_W), .HI_W(HI_W)) u_chk (.*);

// File: tb/mux_bus_slave_bench.sv
`timescale 1ns/1ps
module mux_bus_slave_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  ad_i = 8'h00;
  logic [4:0]  hi_i = 5'h00;
  logic        ale_i = 1'b0, cs_n_i = 1'b1;
  logic        fetch_n_i = 1'b1, rd_n_i = 1'b1, wr_n_i = 1'b1;
  logic [7:0]  ad_o, mem_wdata_o;
  logic        ad_oe_o, mem_rd_o, mem_wr_o;
  logic [12:0] mem_addr_o;
  logic [7:0]  mem_rdata_i = 8'h00;

  always #10 clk = ~clk;

  mux_bus_slave u_mux_bus_slave (.*);

  function automatic logic [7:0] pat(input logic [12:0] a);
    return a[7:0] ^ {a[12:8], 3'b101};
  endfunction

  always @(posedge clk) if (mem_rd_o) mem_rdata_i <= pat(mem_addr_o);

  int rd_cnt = 0, wr_cnt = 0;
  logic [12:0] rd_addr = '0, wr_addr = '0;
  logic [7:0]  wr_data = '0;
  always @(negedge clk) begin
    if (mem_rd_o) begin rd_cnt++; rd_addr = mem_addr_o; end
    if (mem_wr_o) begin wr_cnt++; wr_addr = mem_addr_o; wr_data = mem_wdata_o; end
  end

  int nchk = 0, nfail = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic latch(input logic [12:0] a, input logic csn);
    ale_i = 1'b1; ad_i = a[7:0]; hi_i = a[12:8]; cs_n_i = csn;
    cyc(4);
    ale_i = 1'b0;
    cyc(4);
    ad_i = ~a[7:0];
  endtask

  task automatic do_read(input bit fetch, input logic [12:0] a, input string req, input int hold);
    int c0 = rd_cnt;
    if (fetch) fetch_n_i = 1'b0; else rd_n_i = 1'b0;
    cyc(hold);
    chk(ad_oe_o == 1'b1, req, ad_oe_o, 1);
    chk(ad_o == pat(a), req, ad_o, pat(a));
    chk(rd_cnt == c0 + 1, req, rd_cnt - c0, 1);
    chk(rd_addr == a, req, rd_addr, a);
    fetch_n_i = 1'b1; rd_n_i = 1'b1;
    cyc(3);
    chk(ad_oe_o == 1'b0, "R8 release", ad_oe_o, 0);
    cyc(2);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_n_i = 1'b0; ad_i = d;
    cyc(4);
    wr_n_i = 1'b1;
    cyc(3);
    ad_i = ~d;
    cyc(3);
  endtask

  task automatic t_reset;
    cyc(1);
    chk(ad_oe_o == 0 && mem_rd_o == 0 && mem_wr_o == 0, "R1 reset",
        {ad_oe_o, mem_rd_o, mem_wr_o}, 0);
    rst_n = 1'b1;
    cyc(4);
  endtask

  task automatic t_fetch;
    latch(13'h1A5C, 1'b0);
    do_read(1'b1, 13'h1A5C, "R4 fetch R2 R11", 8);
  endtask

  task automatic t_read;
    latch(13'h0033, 1'b0);
    do_read(1'b0, 13'h0033, "R5 data read", 8);
  endtask

  task automatic t_write;
    int c0;
    latch(13'h17F0, 1'b0);
    c0 = wr_cnt;
    do_write(8'hC3);
    chk(wr_cnt == c0 + 1, "R6 count", wr_cnt - c0, 1);
    chk(wr_addr == 13'h17F0, "R6 addr", wr_addr, 13'h17F0);
    chk(wr_data == 8'hC3, "R6 data", wr_data, 8'hC3);
  endtask

  task automatic t_deselect;
    int r0, w0;
    latch(13'h0444, 1'b1);
    cs_n_i = 1'b0;
    r0 = rd_cnt; w0 = wr_cnt;
    fetch_n_i = 1'b0; cyc(8);
    chk(ad_oe_o == 0, "R3 oe", ad_oe_o, 0);
    fetch_n_i = 1'b1; cyc(3);
    rd_n_i = 1'b0; cyc(8); rd_n_i = 1'b1; cyc(3);
    do_write(8'h11);
    chk(rd_cnt == r0, "R3 reads", rd_cnt - r0, 0);
    chk(wr_cnt == w0, "R3 writes", wr_cnt - w0, 0);
  endtask

  task automatic t_illegal;
    int r0, w0;
    latch(13'h0808, 1'b0);
    r0 = rd_cnt; w0 = wr_cnt;
    fetch_n_i = 1'b0; rd_n_i = 1'b0;
    cyc(8);
    chk(ad_oe_o == 0, "R7 oe", ad_oe_o, 0);
    fetch_n_i = 1'b1; rd_n_i = 1'b1; wr_n_i = 1'b1;
    cyc(1);
    chk(rd_cnt == r0, "R7 no read", rd_cnt - r0, 0);
    cyc(3);
    wr_n_i = 1'b0; ad_i = 8'h77; cyc(4);
    rd_n_i = 1'b0; cyc(4);
    wr_n_i = 1'b1; rd_n_i = 1'b1; cyc(8);
    chk(wr_cnt == w0, "R7 write cancelled", wr_cnt - w0, 0);
  endtask

  task automatic t_long;
    latch(13'h1FFF, 1'b0);
    do_read(1'b0, 13'h1FFF, "R9 long strobe", 60);
  endtask

  task automatic t_same_edge;
    int w0;
    logic [12:0] b = {5'h09, 8'h5E};
    latch(13'h0C21, 1'b0);
    w0 = wr_cnt;
    wr_n_i = 1'b0; ad_i = 8'h5E; cyc(4);
    ale_i = 1'b1; ad_i = b[7:0]; hi_i = b[12:8]; cyc(4);
    ale_i = 1'b0; wr_n_i = 1'b1; cyc(6);
    chk(wr_cnt == w0 + 1, "R6 same-edge count", wr_cnt - w0, 1);
    chk(wr_addr == 13'h0C21, "R2 same-edge old addr", wr_addr, 13'h0C21);
    chk(wr_data == 8'h5E, "R6 same-edge data", wr_data, 8'h5E);
    ad_i = 8'h00;
    do_read(1'b0, b, "R2 same-edge new addr", 8);
  endtask

  initial begin
    t_reset;
    t_fetch;
    t_read;
    t_write;
    t_deselect;
    t_illegal;
    t_long;
    t_same_edge;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end
endmodule